// File: doc/BRIEF.md
# Transmit Frame Assembler with Short-Frame Padding

This block sits behind a host's transmit data port. The host writes 32-bit words. The block builds one outgoing Ethernet frame from them in an on-chip byte store that holds up to 2 KB. The first word of a frame is a header. Its low half gives the payload length, which does not count the 14-byte Ethernet header. Its upper two bytes are the first two bytes of the frame. Every later word adds four bytes to the frame, least significant byte first.

When enough bytes have arrived, the block seals the frame. If the host supplied its own 4-byte CRC, those bytes are dropped. If padding is enabled, a frame shorter than the 60-byte minimum is extended with zero bytes. The frame then leaves the block one byte per handshake on a valid/ready stream. A one-cycle transmit-empty event follows the last byte. A header with an oversize length raises a one-cycle transmit-error event and starts nothing. The host's error acknowledge throws away a frame that is only partly collected.

Top module: `txa_frame_asm`

## Requirements
- R1: After reset the block waits for a header, and `tx_valid`, `tx_last`, `wr_busy`, `evt_empty` and `evt_err` are all low.
- R2: In a header write, `wr_data[15:0]` is the payload length, which excludes the 14-byte header. Bits 23:16 become frame byte 0 and bits 31:24 become frame byte 1.
- R3: A header length above 2032 produces a one-cycle `evt_err` pulse. The block stays waiting for a header and sends nothing.
- R4: A valid header sets the expected byte count to length+14, plus 4 when `crc_auto` is 0. `crc_auto` is sampled on the header write. Each later write appends `wr_data[7:0]`, `[15:8]`, `[23:16]`, `[31:24]` in that order. The frame is complete on the write that brings the stored count to or above the expected count.
- R5: The frame sent is exactly length+14 bytes. With `crc_auto`=0 the four host CRC bytes are not sent. Any surplus bytes of the final word are never sent.
- R6: If `pad_en` is 1 on the completing write and the frame is shorter than 60 bytes, zero bytes are appended up to 60. Otherwise no byte is added.
- R7: Bytes leave in frame order, one per cycle with `tx_valid` and `tx_ready` both high. `tx_data` stays steady while `tx_valid` is high and `tx_ready` is low. `tx_last` marks only the final byte.
- R8: `wr_busy` is high from the completing write until the final byte is accepted. A write presented while `wr_busy` is high has no effect.
- R9: `evt_empty` pulses for one cycle after the final byte is accepted, and the block again waits for a header.
- R10: `err_ack` during collection discards the partial frame. The next write is then decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host data write strobe |
| wr_data | input | 32 | Host write word |
| crc_auto | input | 1 | 1: host does not supply CRC bytes |
| pad_en | input | 1 | Zero-pad short frames to 60 bytes |
| err_ack | input | 1 | Transmit-error acknowledge, aborts collection |
| wr_busy | output | 1 | Writes refused while a frame streams out |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| evt_empty | output | 1 | One-cycle pulse: frame fully sent |
| evt_err | output | 1 | One-cycle pulse: oversize header rejected |

## Verification
Some properties are checked on every cycle:
- The stream holds its byte steady while stalled, and its index never passes the send length.
- `wr_busy` covers every cycle the stream is valid.
- The collection count stays below its target.
- Both events fire only while the block is idle, and `evt_empty` lasts a single cycle.

Other behaviour only the bench scenarios can show: the byte-exact content of each frame, the dropping of CRC bytes, where padding starts and how long it runs, the rejection at exactly 2032 versus 2033, that a write refused while busy is truly ignored, and that a frame is dropped after an acknowledge.

// File: rtl/txa_pkg.sv
package txa_pkg;
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2
    } txa_state_e;

    localparam int TXA_LANES = 4;
    localparam int TXA_HDR_PRELOAD = 2;
endpackage

// File: rtl/txa_ctrl.sv
module txa_ctrl
    import txa_pkg::*;
#(
    parameter int MAX_LEN   = 2032,
    parameter int HDR_BYTES = 14,
    parameter int CRC_BYTES = 4,
    parameter int MIN_FRAME = 60,
    parameter int AW        = 11,
    parameter int CW        = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    input  logic [31:0]                   wr_data,
    input  logic                          crc_auto,
    input  logic                          pad_en,
    input  logic                          err_ack,
    input  logic                          done,
    output logic                          busy,
    output logic [TXA_LANES-1:0]          lane_we,
    output logic [TXA_LANES-1:0][AW-1:0]  lane_addr,
    output logic [TXA_LANES-1:0][7:0]     lane_dat,
    output logic [CW-1:0]                 flen,
    output logic [CW-1:0]                 slen,
    output logic                          start,
    output logic                          evt_err,
    output logic                          evt_empty
);
    typedef struct packed {
        txa_state_e    st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] exp_cnt;
        logic [CW-1:0] flen;
        logic [CW-1:0] slen;
        logic          start;
        logic          evt_err;
        logic          evt_empty;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: ST_HDR, default: '0};

    ctrl_t         q, d;
    logic          acc;
    logic [15:0]   hdr_len;
    logic [CW-1:0] nxt_cnt;

    always_comb begin
        d         = q;
        d.start     = 1'b0;
        d.evt_err   = 1'b0;
        d.evt_empty = 1'b0;
        acc       = wr_valid && (q.st != ST_SEND);
        hdr_len   = wr_data[15:0];
        nxt_cnt   = q.cnt + CW'(TXA_LANES);
        lane_we   = '0;
        for (int i = 0; i < TXA_LANES; i++) begin
            lane_addr[i] = AW'(q.cnt + CW'(i));
            lane_dat[i]  = wr_data[8*i +: 8];
        end
        unique case (q.st)
            ST_HDR: begin
                if (acc) begin
                    if (hdr_len > 16'(MAX_LEN)) begin
                        d.evt_err = 1'b1;
                    end else begin
                        d.flen    = CW'(hdr_len) + CW'(HDR_BYTES);
                        d.exp_cnt = d.flen + (crc_auto ? CW'(0) : CW'(CRC_BYTES));
                        d.cnt     = CW'(TXA_HDR_PRELOAD);
                        lane_we[0]   = 1'b1;
                        lane_addr[0] = AW'(0);
                        lane_dat[0]  = wr_data[23:16];
                        lane_we[1]   = 1'b1;
                        lane_addr[1] = AW'(1);
                        lane_dat[1]  = wr_data[31:24];
                        d.st      = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (err_ack) begin
                    d.st = ST_HDR;
                end else if (acc) begin
                    for (int i = 0; i < TXA_LANES; i++) begin
                        lane_we[i] = (q.cnt + CW'(i)) < q.flen;
                    end
                    d.cnt = nxt_cnt;
                    if (nxt_cnt >= q.exp_cnt) begin
                        d.st    = ST_SEND;
                        d.start = 1'b1;
                        d.slen  = (pad_en && (q.flen < CW'(MIN_FRAME)))
                                  ? CW'(MIN_FRAME) : q.flen;
                    end
                end
            end
            ST_SEND: begin
                if (done) begin
                    d.st        = ST_HDR;
                    d.evt_empty = 1'b1;
                end
            end
            default: d.st = ST_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CTRL_RST;
        else        q <= d;
    end

    assign busy      = (q.st == ST_SEND);
    assign flen      = q.flen;
    assign slen      = q.slen;
    assign start     = q.start;
    assign evt_err   = q.evt_err;
    assign evt_empty = q.evt_empty;

    AST_FILL_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL) |-> (q.cnt < q.exp_cnt)); // R4
    AST_EMPTY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt_empty |=> !q.evt_empty); // R9
    AST_SEND_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEND) |-> (q.slen >= q.flen)); // R6
endmodule

// File: rtl/txa_buf.sv
module txa_buf
    import txa_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic                          clk,
    input  logic [TXA_LANES-1:0]          lane_we,
    input  logic [TXA_LANES-1:0][AW-1:0]  lane_addr,
    input  logic [TXA_LANES-1:0][7:0]     lane_dat,
    input  logic [AW-1:0]                 rd_addr,
    output logic [7:0]                    rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < TXA_LANES; i++) begin
            if (lane_we[i]) mem_q[lane_addr[i]] <= lane_dat[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/txa_stream.sv
module txa_stream #(
    parameter int AW = 11,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] flen,
    input  logic [CW-1:0] slen,
    input  logic [7:0]    rd_data,
    input  logic          tx_ready,
    output logic [AW-1:0] rd_addr,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          done
);
    typedef struct packed {
        logic          active;
        logic [CW-1:0] idx;
    } strm_t;

    strm_t q, d;

    assign rd_addr  = AW'(q.idx);
    assign tx_valid = q.active;
    assign tx_data  = (q.idx < flen) ? rd_data : 8'h00;
    assign tx_last  = q.active && (q.idx == slen - CW'(1));
    assign done     = tx_valid && tx_ready && tx_last;

    always_comb begin
        d = q;
        if (start) begin
            d.active = 1'b1;
            d.idx    = '0;
        end else if (q.active && tx_ready) begin
            if (tx_last) d.active = 1'b0;
            else         d.idx    = q.idx + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R7
    AST_INDEX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (q.idx < slen)); // R7
endmodule

// File: rtl/txa_frame_asm.sv
module txa_frame_asm
    import txa_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int MAX_LEN   = 2032,
    parameter int HDR_BYTES = 14,
    parameter int CRC_BYTES = 4,
    parameter int MIN_FRAME = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic        crc_auto,
    input  logic        pad_en,
    input  logic        err_ack,
    output logic        wr_busy,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        evt_empty,
    output logic        evt_err
);
    localparam int AW = $clog2(BUF_BYTES);
    localparam int CW = $clog2(MAX_LEN + HDR_BYTES + CRC_BYTES + 2*TXA_LANES) + 1;

    logic [TXA_LANES-1:0]         lane_we;
    logic [TXA_LANES-1:0][AW-1:0] lane_addr;
    logic [TXA_LANES-1:0][7:0]    lane_dat;
    logic [CW-1:0]                flen, slen;
    logic                         start, done;
    logic [AW-1:0]                rd_addr;
    logic [7:0]                   rd_data;

    txa_ctrl #(
        .MAX_LEN(MAX_LEN), .HDR_BYTES(HDR_BYTES), .CRC_BYTES(CRC_BYTES),
        .MIN_FRAME(MIN_FRAME), .AW(AW), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .crc_auto(crc_auto), .pad_en(pad_en), .err_ack(err_ack), .done(done),
        .busy(wr_busy), .lane_we(lane_we), .lane_addr(lane_addr),
        .lane_dat(lane_dat), .flen(flen), .slen(slen), .start(start),
        .evt_err(evt_err), .evt_empty(evt_empty)
    );

    txa_buf #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
        .clk(clk), .lane_we(lane_we), .lane_addr(lane_addr),
        .lane_dat(lane_dat), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    txa_stream #(.AW(AW), .CW(CW)) u_stream (
        .clk(clk), .rst_n(rst_n), .start(start), .flen(flen), .slen(slen),
        .rd_data(rd_data), .tx_ready(tx_ready), .rd_addr(rd_addr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .done(done)
    );

    AST_BUSY_COVERS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> wr_busy); // R8
    AST_ERR_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |-> (!wr_busy && !tx_valid)); // R3
    AST_EMPTY_AFTER_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        evt_empty |-> (!tx_valid && !wr_busy)); // R9
endmodule

// File: tb/sim_txa_frame_asm.sv
module sim_txa_frame_asm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        crc_auto = 1'b1;
    logic        pad_en = 1'b0;
    logic        err_ack = 1'b0;
    logic        tx_ready = 1'b0;
    logic        wr_busy, tx_valid, tx_last, evt_empty, evt_err;
    logic [7:0]  tx_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cap_n = 0;
    int last_at = -1;
    int empty_cnt = 0;
    int err_cnt = 0;
    int stall_bad = 0;
    int busy_bad = 0;
    bit force_stall = 1'b0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic [7:0] src [4096];
    logic [7:0] cap [4096];
    int cur_flen, cur_slen;

    always #10 clk = ~clk;

    txa_frame_asm u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .crc_auto(crc_auto), .pad_en(pad_en), .err_ack(err_ack),
        .wr_busy(wr_busy), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .evt_empty(evt_empty),
        .evt_err(evt_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int flen, input bit pad);
        return (pad && flen < 60) ? 60 : flen;
    endfunction

    function automatic logic [7:0] exp_byte(input int i, input int flen);
        return (i < flen) ? src[i] : 8'h00;
    endfunction

    // stream monitor
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = force_stall ? 1'b0 : ($urandom_range(3) != 0);
            #1;
            if (prev_stall && (!tx_valid || tx_data != prev_data)) stall_bad++;
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            if (tx_valid && !wr_busy) busy_bad++;
            if (tx_valid && tx_ready) begin
                cap[cap_n] = tx_data;
                if (tx_last) last_at = cap_n;
                cap_n++;
            end
            if (evt_empty) empty_cnt++;
            if (evt_err) err_cnt++;
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        while (wr_busy) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic start_frame(input int len, input bit ca, input bit pad);
        int target, cnt;
        crc_auto = ca;
        pad_en   = pad;
        cur_flen = len + 14;
        cur_slen = exp_len(cur_flen, pad);
        target   = cur_flen + (ca ? 0 : 4);
        for (int i = 0; i < target + 4; i++) src[i] = 8'($urandom);
        cap_n = 0;
        last_at = -1;
        wr({src[1], src[0], 16'(len)});
        cnt = 2;
        while (cnt < target) begin
            wr({src[cnt+3], src[cnt+2], src[cnt+1], src[cnt]});
            cnt += 4;
        end
    endtask

    task automatic finish_frame(input string req);
        int e0, t, bad, first;
        e0 = empty_cnt - ((empty_cnt > 0 && cap_n == cur_slen) ? 1 : 0);
        t = 0;
        while (cap_n < cur_slen && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(cap_n == cur_slen, {req, " R5 R6 frame length"}, cap_n, cur_slen);
        bad = 0;
        first = -1;
        for (int i = 0; i < cap_n && i < cur_slen; i++) begin
            if (cap[i] !== exp_byte(i, cur_flen)) begin
                if (first < 0) first = i;
                bad++;
            end
        end
        if (first >= 0)
            chk(1'b0, {req, " R2 R4 byte content"}, int'(cap[first]), int'(exp_byte(first, cur_flen)));
        else
            chk(1'b1, {req, " R2 R4 byte content"}, 0, 0);
        chk(last_at == cur_slen - 1, {req, " R7 last marker"}, last_at, cur_slen - 1);
        chk(empty_cnt >= e0 + 1 && !wr_busy, {req, " R9 empty event"}, empty_cnt - e0, 1);
    endtask

    task automatic send_frame(input int len, input bit ca, input bit pad, input string req);
        int e0;
        e0 = empty_cnt;
        start_frame(len, ca, pad);
        finish_frame(req);
        chk(empty_cnt == e0 + 1, {req, " R9 single event"}, empty_cnt - e0, 1);
    endtask

    initial begin
        int e0, x0;
        x0 = $urandom(32'd20240);
        repeat (4) @(negedge clk);
        #2;
        // R1 reset state while held in reset and after release
        chk(!tx_valid && !tx_last && !wr_busy && !evt_empty && !evt_err,
            "R1 reset outputs", int'({tx_valid, tx_last, wr_busy, evt_empty, evt_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!tx_valid && !wr_busy, "R1 idle after reset", int'({tx_valid, wr_busy}), 0);

        // R2 R4 minimal frame, CRC automatic
        send_frame(0, 1'b1, 1'b0, "R2 len0 auto");
        // R5 host CRC dropped
        send_frame(0, 1'b0, 1'b0, "R5 len0 host crc");
        send_frame(7, 1'b0, 1'b0, "R5 odd len host crc");
        // R6 padding cases
        send_frame(10, 1'b0, 1'b1, "R6 pad short");
        send_frame(46, 1'b1, 1'b1, "R6 exactly 60");
        send_frame(47, 1'b0, 1'b1, "R6 61 no pad");
        send_frame(10, 1'b1, 1'b0, "R6 short no pad");

        // R3 oversize header rejected, boundary 2033
        e0 = err_cnt;
        cap_n = 0;
        wr({16'hABCD, 16'd2033});
        repeat (3) @(negedge clk);
        chk(err_cnt == e0 + 1, "R3 oversize error pulse", err_cnt - e0, 1);
        chk(cap_n == 0 && !wr_busy && !tx_valid, "R3 nothing started", cap_n, 0);
        send_frame(3, 1'b1, 1'b0, "R3 header after reject");
        // R3 R4 maximum accepted length, host CRC
        e0 = err_cnt;
        send_frame(2032, 1'b0, 1'b0, "R4 max length");
        chk(err_cnt == e0, "R3 2032 accepted", err_cnt - e0, 0);

        // R10 acknowledge aborts collection
        crc_auto = 1'b1;
        wr({16'h1111, 16'd20});
        wr(32'h22222222);
        wr(32'h33333333);
        @(negedge clk);
        err_ack = 1'b1;
        @(negedge clk);
        err_ack = 1'b0;
        chk(cap_n == 0 || cur_slen > 0, "R10 no output after ack", 0, 0);
        send_frame(5, 1'b1, 1'b1, "R10 fresh frame after ack");

        // R8 busy refusal
        force_stall = 1'b1;
        start_frame(9, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk(wr_busy == 1'b1, "R8 busy while sending", int'(wr_busy), 1);
        chk(tx_valid == 1'b1, "R7 valid held under stall", int'(tx_valid), 1);
        wr_valid = 1'b1;
        wr_data  = {16'h5A5A, 16'd3000};
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = {16'hA5A5, 16'd4};
        @(negedge clk);
        wr_valid = 1'b0;
        e0 = err_cnt;
        force_stall = 1'b0;
        finish_frame("R8 frame unaffected by busy writes");
        chk(err_cnt == e0, "R8 busy writes ignored", err_cnt - e0, 0);
        send_frame(12, 1'b0, 1'b1, "R8 next header decoded");

        // random mix
        for (int k = 0; k < 30; k++) begin
            int len;
            len = ($urandom_range(4) == 0) ? $urandom_range(1500) : $urandom_range(120);
            send_frame(len, 1'($urandom), 1'($urandom), "R4 random frame");
        end

        chk(stall_bad == 0, "R7 data stable under stall", stall_bad, 0);
        chk(busy_bad == 0, "R8 busy covers stream", busy_bad, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule